// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block keeps a small file of 16-bit data pointers and produces the effective data-memory address for indirect transfers between the working register and memory. Each request picks one pointer and an access mode. A mode can step the pointer up or down before or after the access, add a signed 6-bit displacement without changing the pointer, or adjust the pointer by that displacement without making an access. Software reaches each pointer one byte at a time through a byte-wide write port and a byte-wide read port.

Each effective address is sorted into a region. A linear window is folded back onto the banked general-purpose RAM segments, so the memory side receives a physical address in the banked form. Flash addresses and all other addresses pass through unchanged. The memory array and the instruction decoder sit outside this block. All outputs are registered and appear one clock after the request.

Top module: `ind_ptr_unit`

## Requirements
- R1: On a synchronous active-high reset, every pointer becomes 0x0000, and `acc_valid_o`, `acc_addr_o`, `acc_region_o`, `acc_phys_o` and `rd_data_o` become zero.
- R2: When `wr_en_i` is high, `wr_data_i` is written at the clock edge into the pointer that `wr_sel_i` selects. It goes to bits 15:8 when `wr_hi_i`=1 and to bits 7:0 otherwise. `rd_data_o` shows, one clock later, byte `rd_hi_i` of pointer `rd_sel_i` as it stood before that edge.
- R3: For op 1 (pre-increment) and op 2 (pre-decrement), the selected pointer changes by +1 or -1. The changed value is reported as the access address on the next cycle, with `acc_valid_o`=1.
- R4: For op 3 (post-increment) and op 4 (post-decrement), the access address is the pointer before the change. The pointer then changes by +1 or -1.
- R5: For op 5 (indexed), the access address is the pointer plus the 6-bit `imm_i` sign-extended to 16 bits. The pointer does not change.
- R6: For op 6 (adjust), the pointer gains the sign-extended `imm_i`. `acc_valid_o` is 0 on the next cycle, and the address, region and physical outputs keep their previous values. Op 0 and op 7 are idle and behave the same way for those outputs, without touching any pointer.
- R7: All pointer and address arithmetic wraps modulo 2^16.
- R8: A byte write to the pointer that the op selects, made in the same cycle, overrides that op's pointer change: only the written byte changes. An op on the other pointer still takes effect.
- R9: `acc_region_o` is 0 for addresses below 0x2000, 1 for 0x2000 to 0x29AF, 3 for 0x29B0 to 0x7FFF and 2 for 0x8000 and above. Region 2 is flash, where only the low byte of each word is returned.
- R10: In region 1, with k = address - 0x2000, `acc_phys_o` = ((k / 80) << 7) | (0x20 + k mod 80). In every other region, `acc_phys_o` equals the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Access mode: 0 idle, 1 pre-inc, 2 pre-dec, 3 post-inc, 4 post-dec, 5 indexed, 6 adjust, 7 idle |
| sel_i | input | 1 | Pointer used by the op |
| imm_i | input | 6 | Signed displacement for indexed and adjust |
| wr_en_i | input | 1 | Pointer byte write enable |
| wr_sel_i | input | 1 | Pointer to write |
| wr_hi_i | input | 1 | 1 = high byte, 0 = low byte |
| wr_data_i | input | 8 | Byte to write |
| rd_sel_i | input | 1 | Pointer to read |
| rd_hi_i | input | 1 | 1 = high byte, 0 = low byte |
| rd_data_o | output | 8 | Registered read byte |
| acc_valid_o | output | 1 | An access address was produced |
| acc_addr_o | output | 16 | Effective address |
| acc_region_o | output | 2 | Region code |
| acc_phys_o | output | 16 | Physical address after linear folding |

## Verification
The bench goes after the edges of the linear window: 0x1FFF, 0x2000, 0x204F, 0x2050, 0x29AF and 0x29B0. An off-by-one in the bounds or in the segment split would misreport a region or place a byte in the wrong bank. It tests 0xFFFF to 0x0000 wrap in both directions, and displacements of +31, -1 and -32, which a zero-extending design would turn into large forward jumps. It also checks that pre- and post-modes report different addresses, since a swapped design would be off by one in every access. Finally, it makes byte writes collide with an op on the same pointer and on the other pointer; a design with the wrong priority would either lose the written byte or drop the change to the other pointer.

// File: rtl/ind_ptr_pkg.sv
package ind_ptr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PREINC  = 3'd1,
    OP_PREDEC  = 3'd2,
    OP_POSTINC = 3'd3,
    OP_POSTDEC = 3'd4,
    OP_INDEX   = 3'd5,
    OP_ADJUST  = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RG_BANKED = 2'd0,
    RG_LINEAR = 2'd1,
    RG_FLASH  = 2'd2,
    RG_VOID   = 2'd3
  } region_e;
endpackage

// File: rtl/ind_ptr_regs.sv
module ind_ptr_regs #(
  parameter int NPTR = 2,
  parameter int AW   = 16,
  parameter int BW   = 8,
  parameter int SW   = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SW-1:0]            wr_sel,
  input  logic                     wr_hi,
  input  logic [BW-1:0]            wr_data,
  input  logic                     upd_en,
  input  logic [SW-1:0]            upd_sel,
  input  logic [AW-1:0]            upd_val,
  output logic [NPTR-1:0][AW-1:0]  ptrs
);
  localparam int HI_W = AW - BW;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic hit_wr;
    logic hit_upd;
    assign hit_wr  = wr_en  && (wr_sel  == SW'(g));
    assign hit_upd = upd_en && (upd_sel == SW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ptrs[g] <= '0;
      end else if (hit_wr) begin
        if (wr_hi) ptrs[g][AW-1 -: HI_W] <= HI_W'(wr_data);
        else       ptrs[g][BW-1:0]       <= wr_data;
      end else if (hit_upd) begin
        ptrs[g] <= upd_val;
      end
    end
  end
endmodule

// File: rtl/ind_ptr_agen.sv
module ind_ptr_agen
  import ind_ptr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int IMMW = 6
) (
  input  logic [2:0]      op,
  input  logic [AW-1:0]   base,
  input  logic [IMMW-1:0] imm,
  output logic            acc_en,
  output logic [AW-1:0]   acc_addr,
  output logic            upd_en,
  output logic [AW-1:0]   upd_val
);
  localparam int EXT_W = AW - IMMW;

  logic [AW-1:0] disp;
  logic [AW-1:0] inc;
  logic [AW-1:0] dec;
  logic [AW-1:0] idx;
  op_e           opc;

  assign opc  = op_e'(op);
  assign disp = {{EXT_W{imm[IMMW-1]}}, imm};
  assign inc  = base + AW'(1);
  assign dec  = base - AW'(1);
  assign idx  = base + disp;

  always_comb begin
    acc_en   = 1'b0;
    acc_addr = base;
    upd_en   = 1'b0;
    upd_val  = base;
    case (opc)
      OP_PREINC:  begin acc_en = 1'b1; acc_addr = inc;  upd_en = 1'b1; upd_val = inc; end
      OP_PREDEC:  begin acc_en = 1'b1; acc_addr = dec;  upd_en = 1'b1; upd_val = dec; end
      OP_POSTINC: begin acc_en = 1'b1; acc_addr = base; upd_en = 1'b1; upd_val = inc; end
      OP_POSTDEC: begin acc_en = 1'b1; acc_addr = base; upd_en = 1'b1; upd_val = dec; end
      OP_INDEX:   begin acc_en = 1'b1; acc_addr = idx; end
      OP_ADJUST:  begin upd_en = 1'b1; upd_val = idx; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/ind_ptr_region.sv
module ind_ptr_region
  import ind_ptr_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LIN_BASE   = 'h2000,
  parameter int SEG_BYTES  = 80,
  parameter int LIN_SEGS   = 31,
  parameter int SEG_BASE   = 'h20,
  parameter int BANK_SHIFT = 7,
  parameter int FLASH_BASE = 'h8000
) (
  input  logic [AW-1:0] addr,
  output logic [1:0]    region,
  output logic [AW-1:0] phys
);
  localparam logic [AW-1:0] LIN_LO  = AW'(LIN_BASE);
  localparam logic [AW-1:0] LIN_HI  = AW'(LIN_BASE + SEG_BYTES * LIN_SEGS);
  localparam logic [AW-1:0] FL_LO   = AW'(FLASH_BASE);
  localparam logic [AW-1:0] SEG_SZ  = AW'(SEG_BYTES);
  localparam logic [AW-1:0] SEG_OFS = AW'(SEG_BASE);

  logic [AW-1:0] off;
  logic [AW-1:0] bank;
  logic [AW-1:0] slot;
  logic          in_lin;

  assign off    = addr - LIN_LO;
  assign bank   = off / SEG_SZ;
  assign slot   = off % SEG_SZ;
  assign in_lin = (addr >= LIN_LO) && (addr < LIN_HI);

  always_comb begin
    if (addr >= FL_LO)      region = RG_FLASH;
    else if (in_lin)        region = RG_LINEAR;
    else if (addr < LIN_LO) region = RG_BANKED;
    else                    region = RG_VOID;
  end

  assign phys = in_lin ? ((bank << BANK_SHIFT) | (SEG_OFS + slot)) : addr;
endmodule

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit
  import ind_ptr_pkg::*;
#(
  parameter int NPTR       = 2,
  parameter int AW         = 16,
  parameter int BW         = 8,
  parameter int IMMW       = 6,
  parameter int LIN_BASE   = 'h2000,
  parameter int SEG_BYTES  = 80,
  parameter int LIN_SEGS   = 31,
  parameter int SEG_BASE   = 'h20,
  parameter int BANK_SHIFT = 7,
  parameter int FLASH_BASE = 'h8000,
  localparam int SW        = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      op_i,
  input  logic [SW-1:0]   sel_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            wr_en_i,
  input  logic [SW-1:0]   wr_sel_i,
  input  logic            wr_hi_i,
  input  logic [BW-1:0]   wr_data_i,
  input  logic [SW-1:0]   rd_sel_i,
  input  logic            rd_hi_i,
  output logic [BW-1:0]   rd_data_o,
  output logic            acc_valid_o,
  output logic [AW-1:0]   acc_addr_o,
  output logic [1:0]      acc_region_o,
  output logic [AW-1:0]   acc_phys_o
);
  logic [NPTR-1:0][AW-1:0] ptrs;
  logic [AW-1:0]           base;
  logic                    acc_en;
  logic [AW-1:0]           acc_addr;
  logic                    upd_en;
  logic [AW-1:0]           upd_val;
  logic [1:0]              region;
  logic [AW-1:0]           phys;
  logic [AW-1:0]           rd_word;

  assign base    = ptrs[sel_i];
  assign rd_word = ptrs[rd_sel_i];

  ind_ptr_regs #(.NPTR(NPTR), .AW(AW), .BW(BW), .SW(SW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_hi   (wr_hi_i),
    .wr_data (wr_data_i),
    .upd_en  (upd_en),
    .upd_sel (sel_i),
    .upd_val (upd_val),
    .ptrs    (ptrs)
  );

  ind_ptr_agen #(.AW(AW), .IMMW(IMMW)) u_agen (
    .op       (op_i),
    .base     (base),
    .imm      (imm_i),
    .acc_en   (acc_en),
    .acc_addr (acc_addr),
    .upd_en   (upd_en),
    .upd_val  (upd_val)
  );

  ind_ptr_region #(
    .AW(AW), .LIN_BASE(LIN_BASE), .SEG_BYTES(SEG_BYTES), .LIN_SEGS(LIN_SEGS),
    .SEG_BASE(SEG_BASE), .BANK_SHIFT(BANK_SHIFT), .FLASH_BASE(FLASH_BASE)
  ) u_region (
    .addr   (acc_addr),
    .region (region),
    .phys   (phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid_o  <= 1'b0;
      acc_addr_o   <= '0;
      acc_region_o <= '0;
      acc_phys_o   <= '0;
      rd_data_o    <= '0;
    end else begin
      acc_valid_o <= acc_en;
      rd_data_o   <= rd_hi_i ? rd_word[AW-1 -: BW] : rd_word[BW-1:0];
      if (acc_en) begin
        acc_addr_o   <= acc_addr;
        acc_region_o <= region;
        acc_phys_o   <= phys;
      end
    end
  end
endmodule

// File: rtl/ind_ptr_chk.sv
module ind_ptr_chk
  import ind_ptr_pkg::*;
#(
  parameter int NPTR       = 2,
  parameter int AW         = 16,
  parameter int SEG_BYTES  = 80,
  parameter int SEG_BASE   = 'h20,
  parameter int BANK_SHIFT = 7,
  localparam int SW        = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [2:0]              op_i,
  input logic [SW-1:0]           sel_i,
  input logic                    wr_en_i,
  input logic [SW-1:0]           wr_sel_i,
  input logic                    acc_valid_o,
  input logic [AW-1:0]           acc_addr_o,
  input logic [1:0]              acc_region_o,
  input logic [AW-1:0]           acc_phys_o,
  input logic [NPTR-1:0][AW-1:0] ptrs
);
  localparam logic [BANK_SHIFT-1:0] SLOT_LO = BANK_SHIFT'(SEG_BASE);
  localparam logic [BANK_SHIFT-1:0] SLOT_HI = BANK_SHIFT'(SEG_BASE + SEG_BYTES);

  // R3
  pre_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PREINC || op_i == OP_PREDEC) && !(wr_en_i && wr_sel_i == sel_i)
    |=> acc_addr_o == ptrs[$past(sel_i)]);

  // R4
  post_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_POSTINC || op_i == OP_POSTDEC) |=> acc_addr_o == $past(ptrs[sel_i]));

  // R5
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INDEX) && !wr_en_i |=> $stable(ptrs));

  // R6
  adj_novalid_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADJUST) |=> !acc_valid_o);

  // R9
  flash_addr_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid_o && acc_region_o == RG_FLASH |-> acc_addr_o[AW-1]);

  // R10
  lin_phys_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid_o && acc_region_o == RG_LINEAR |->
      acc_phys_o[BANK_SHIFT-1:0] >= SLOT_LO && acc_phys_o[BANK_SHIFT-1:0] < SLOT_HI);
endmodule

bind ind_ptr_unit ind_ptr_chk #(
  .NPTR(NPTR), .AW(AW), .SEG_BYTES(SEG_BYTES), .SEG_BASE(SEG_BASE), .BANK_SHIFT(BANK_SHIFT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_i         (op_i),
  .sel_i        (sel_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .acc_valid_o  (acc_valid_o),
  .acc_addr_o   (acc_addr_o),
  .acc_region_o (acc_region_o),
  .acc_phys_o   (acc_phys_o),
  .ptrs         (ptrs)
);

// File: tb/test_ind_ptr_unit.sv
module test_ind_ptr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op = 3'd0;
  logic       sel = 1'b0;
  logic [5:0] imm = '0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0, rd_hi = 1'b0;
  logic [7:0] rd_data;
  logic       acc_valid;
  logic [15:0] acc_addr, acc_phys;
  logic [1:0] acc_region;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  logic [15:0] mp [2];
  logic        e_valid;
  logic [15:0] e_addr, e_phys;
  logic [1:0]  e_rgn;
  logic [7:0]  e_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_ptr_unit i_ind_ptr_unit (
    .clk(clk), .rst(rst), .op_i(op), .sel_i(sel), .imm_i(imm),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_hi_i(rd_hi), .rd_data_o(rd_data),
    .acc_valid_o(acc_valid), .acc_addr_o(acc_addr),
    .acc_region_o(acc_region), .acc_phys_o(acc_phys)
  );

  function automatic logic [1:0] ref_rgn(int a);
    if (a >= 32768) return 2'd2;
    if (a < 8192) return 2'd0;
    if (a < 8192 + 31 * 80) return 2'd1;
    return 2'd3;
  endfunction

  function automatic logic [15:0] ref_phys(int a);
    int k;
    if (ref_rgn(a) != 2'd1) return 16'(a);
    k = a - 8192;
    return 16'((k / 80) * 128 + 32 + (k % 80));
  endfunction

  // Behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      mp[0] = 16'h0; mp[1] = 16'h0;
      e_valid = 1'b0; e_addr = 16'h0; e_phys = 16'h0; e_rgn = 2'd0; e_rd = 8'h0;
    end else begin
      int b, s, a, nv;
      bit acc, upd;
      e_rd = rd_hi ? mp[rd_sel][15:8] : mp[rd_sel][7:0];
      b = int'(mp[sel]);
      s = imm[5] ? int'(imm) - 64 : int'(imm);
      acc = 0; upd = 0; a = b; nv = b;
      case (op)
        3'd1: begin acc = 1; upd = 1; nv = b + 1; a = nv; end
        3'd2: begin acc = 1; upd = 1; nv = b - 1; a = nv; end
        3'd3: begin acc = 1; upd = 1; nv = b + 1; end
        3'd4: begin acc = 1; upd = 1; nv = b - 1; end
        3'd5: begin acc = 1; a = b + s; end
        3'd6: begin upd = 1; nv = b + s; end
        default: ;
      endcase
      a  = a & 16'hFFFF;
      nv = nv & 16'hFFFF;
      e_valid = acc;
      if (acc) begin
        e_addr = 16'(a); e_rgn = ref_rgn(a); e_phys = ref_phys(a);
      end
      if (upd && !(wr_en && wr_sel == sel)) mp[sel] = 16'(nv);
      if (wr_en) begin
        if (wr_hi) mp[wr_sel][15:8] = wr_data;
        else       mp[wr_sel][7:0]  = wr_data;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(rd_data == e_rd, "rd_data", int'(rd_data), int'(e_rd));
    chk(acc_valid == e_valid, "acc_valid", int'(acc_valid), int'(e_valid));
    chk(acc_addr == e_addr, "acc_addr", int'(acc_addr), int'(e_addr));
    chk(acc_region == e_rgn, "acc_region", int'(acc_region), int'(e_rgn));
    chk(acc_phys == e_phys, "acc_phys", int'(acc_phys), int'(e_phys));
  endtask

  task automatic step(input logic [2:0] o, input logic s, input logic [5:0] im,
                      input logic we, input logic ws, input logic wh, input logic [7:0] wd,
                      input logic rs, input logic rh);
    op = o; sel = s; imm = im; wr_en = we; wr_sel = ws; wr_hi = wh; wr_data = wd;
    rd_sel = rs; rd_hi = rh;
    @(negedge clk);
    compare();
  endtask

  task automatic op_only(input logic [2:0] o, input logic s, input logic [5:0] im);
    step(o, s, im, 1'b0, 1'b0, 1'b0, 8'h0, s, 1'b0);
  endtask

  task automatic load(input logic p, input logic [15:0] v);
    step(3'd0, 1'b0, 6'h0, 1'b1, p, 1'b0, v[7:0], p, 1'b0);
    step(3'd0, 1'b0, 6'h0, 1'b1, p, 1'b1, v[15:8], p, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst = 1'b0;
    step(3'd0, 1'b0, 6'h0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b1);
    step(3'd0, 1'b0, 6'h0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b1, 1'b0);

    cur_req = "R2";
    load(1'b0, 16'h2005);
    load(1'b1, 16'h8010);
    step(3'd0, 1'b0, 6'h0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b1);
    step(3'd0, 1'b0, 6'h0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b1, 1'b0);

    cur_req = "R3";
    repeat (3) op_only(3'd1, 1'b0, 6'h0);
    op_only(3'd2, 1'b1, 6'h0);

    cur_req = "R4";
    op_only(3'd3, 1'b0, 6'h0);
    op_only(3'd4, 1'b1, 6'h0);
    op_only(3'd3, 1'b1, 6'h0);

    cur_req = "R5";
    op_only(3'd5, 1'b0, 6'h3F);
    op_only(3'd5, 1'b0, 6'h1F);
    op_only(3'd5, 1'b0, 6'h20);
    op_only(3'd0, 1'b0, 6'h0);

    cur_req = "R6";
    op_only(3'd6, 1'b0, 6'h20);
    op_only(3'd6, 1'b1, 6'h1F);
    op_only(3'd7, 1'b0, 6'h0);
    op_only(3'd5, 1'b0, 6'h00);

    cur_req = "R7";
    load(1'b1, 16'hFFFF);
    op_only(3'd3, 1'b1, 6'h0);
    op_only(3'd2, 1'b1, 6'h0);
    op_only(3'd6, 1'b1, 6'h01);
    op_only(3'd5, 1'b1, 6'h3E);

    cur_req = "R8";
    load(1'b0, 16'h1234);
    step(3'd1, 1'b0, 6'h0, 1'b1, 1'b0, 1'b1, 8'hAB, 1'b0, 1'b1);
    step(3'd3, 1'b1, 6'h0, 1'b1, 1'b0, 1'b0, 8'hCD, 1'b0, 1'b0);
    step(3'd6, 1'b0, 6'h05, 1'b1, 1'b0, 1'b0, 8'h77, 1'b1, 1'b0);
    op_only(3'd5, 1'b0, 6'h0);

    foreach (mp[i]) begin end
    cur_req = "R9";
    for (int n = 0; n < 8; n++) begin
      logic [15:0] pt;
      case (n)
        0: pt = 16'h1FFF; 1: pt = 16'h2000; 2: pt = 16'h29AF; 3: pt = 16'h29B0;
        4: pt = 16'h7FFF; 5: pt = 16'h8000; 6: pt = 16'hFFFF; default: pt = 16'h0000;
      endcase
      load(1'b0, pt);
      op_only(3'd5, 1'b0, 6'h0);
    end

    cur_req = "R10";
    for (int n = 0; n < 6; n++) begin
      logic [15:0] pt;
      case (n)
        0: pt = 16'h204F; 1: pt = 16'h2050; 2: pt = 16'h209F;
        3: pt = 16'h20A0; 4: pt = 16'h2960; default: pt = 16'h2500;
      endcase
      load(1'b1, pt);
      op_only(3'd5, 1'b1, 6'h0);
      op_only(3'd3, 1'b1, 6'h0);
    end

    cur_req = "R7";
    for (int n = 0; n < 600; n++) begin
      step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 6'($urandom_range(0, 63)),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule